// File: doc/BRIEF.md
# Configurable UART Frame Transceiver

This block is a full-duplex asynchronous serial transceiver whose character format is chosen at run time. Pins set the word length (8 or 9 bits), whether parity is used, whether the parity is even or odd, and the stop length. A baud divider sets the oversampling tick rate. Each bit lasts 16 oversampling ticks.

On the transmit side, a valid/ready handshake accepts a data word. Two request inputs make the transmitter emit a whole idle frame or a break frame instead. The line idles high, and bits go out least significant first. When parity is on, the parity bit takes the place of the top bit of the chosen word, so the word carries one data bit fewer.

On the receive side, the line is synchronised and a start bit is detected on a falling edge. The start bit is confirmed at mid-bit, and every later bit is sampled at its centre. Each completed frame is reported with a one-clock valid pulse, the received word, and flags for parity error, framing error and break.

Top module: `uart_frame_xcvr`

## Requirements
- R1: After reset, `txd` is high, `tx_ready` is high and `rx_valid` is low.
- R2: One oversampling tick occurs every `cfg_div` clocks. A value of 0 or 1 gives a tick on every clock. Every bit period is 16 ticks.
- R3: A data frame is a low start bit, then the word least significant bit first, then high stop time. `tx_ready` is low from the accepting clock until the stop time has ended.
- R4: When `cfg_wide`=0 the word is 8 bits: `tx_data[8]` is not sent and `rx_data[8]` reads 0. When `cfg_wide`=1 the word is 9 bits.
- R5: When `cfg_par_en`=1, bit 7 (8-bit words) or bit 8 (9-bit words) is replaced by a parity bit. With `cfg_par_odd`=0 the parity bit makes the count of ones in the whole word even; with `cfg_par_odd`=1 it makes that count odd.
- R6: `cfg_stop` sets the stop time: 2'b00 is 1 bit (16 ticks), 2'b01 is half a bit (8 ticks), 2'b10 is 2 bits (32 ticks), 2'b11 is 1.5 bits (24 ticks).
- R7: `tx_break_req` drives the line low for the start bit, the word and one more bit period. The line then goes high for the longer of the stop setting and one bit. When requests coincide, break wins over idle, and idle wins over data.
- R8: `tx_idle_req` keeps the line high for the start and word bit periods plus the stop time. The receiver reports no frame for it.
- R9: A falling edge starts reception only if the line is still low at tick 8. A shorter low pulse produces no frame.
- R10: Each frame gives a one-clock `rx_valid` pulse with the sampled word. The stop level is sampled 16 ticks after the last word sample, or 12 ticks after it when `cfg_stop`=2'b01.
- R11: `rx_par_err` is set when parity is enabled and the received word does not match the selected parity.
- R12: `rx_frm_err` is set when the stop sample is low.
- R13: `rx_brk` is set when every word bit and the stop sample are low. `rx_frm_err` is then also set, and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Clocks per oversampling tick |
| cfg_wide | input | 1 | 0: 8-bit word, 1: 9-bit word |
| cfg_par_en | input | 1 | Parity replaces the top word bit |
| cfg_par_odd | input | 1 | 0: even parity, 1: odd parity |
| cfg_stop | input | 2 | Stop length code |
| tx_data | input | 9 | Word to send |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Transmitter can accept a request |
| tx_idle_req | input | 1 | Send an idle frame |
| tx_break_req | input | 1 | Send a break frame |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 9 | Received word |
| rx_valid | output | 1 | One-clock pulse per received frame |
| rx_par_err | output | 1 | Parity mismatch on this frame |
| rx_frm_err | output | 1 | Stop sample was low |
| rx_brk | output | 1 | Frame was entirely low |

## Verification
Frames that are wrong on the wire are the hardest to produce, because the transmitter never makes a bad-parity word or a low stop bit on its own. To get them, the bench disconnects the loopback and drives `rxd` bit by bit for parity errors, framing errors and a start glitch that ends before tick 8. The break path is exercised in loopback, with all three transmit requests raised in the same cycle so that priority is tested as well. The half-bit stop needs the receiver's shortened stop sampling point, so that case is also run in loopback.

// File: rtl/uart_fmt_pkg.sv
package uart_fmt_pkg;

   localparam int unsigned WORD_MAX = 9;

   typedef enum logic [1:0] {
      STOP_ONE     = 2'b00,
      STOP_HALF    = 2'b01,
      STOP_TWO     = 2'b10,
      STOP_ONEHALF = 2'b11
   } stop_code_e;

   typedef struct packed {
      logic       wide;
      logic       par_en;
      logic       par_odd;
      stop_code_e stop;
   } frame_cfg_t;

   // Parity bit for the data bits below the top word position
   function automatic logic word_parity(input logic [WORD_MAX-1:0] w,
                                        input logic wide, input logic odd);
      logic p;
      p = wide ? (^w[7:0]) : (^w[6:0]);
      return p ^ odd;
   endfunction

endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q == '0) begin
         cnt_q <= (cfg_div == '0) ? '0 : cfg_div - DIV_W'(1);
      end else begin
         cnt_q <= cnt_q - DIV_W'(1);
      end
   end

   assign tick = (cnt_q == '0);

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cfg_div > DIV_W'(1)) |=> !tick); // R2

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
   import uart_fmt_pkg::*;
#(
   parameter int unsigned OVS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  frame_cfg_t          cfg,
   input  logic [WORD_MAX-1:0] tx_data,
   input  logic                tx_valid,
   input  logic                tx_idle_req,
   input  logic                tx_break_req,
   output logic                tx_ready,
   output logic                txd
);

   localparam int unsigned TW = $clog2(2*OVS + 1);
   localparam int unsigned FW = WORD_MAX + 1;
   localparam logic [TW-1:0] T_BIT     = TW'(OVS);
   localparam logic [TW-1:0] T_HALF    = TW'(OVS/2);
   localparam logic [TW-1:0] T_ONEHALF = TW'(OVS + OVS/2);
   localparam logic [TW-1:0] T_TWO     = TW'(2*OVS);

   typedef enum logic [1:0] {TX_IDLE, TX_BITS, TX_STOP} tx_state_e;

   tx_state_e           state_q;
   logic [FW-1:0]       shreg_q;
   logic [TW-1:0]       tcnt_q;
   logic [3:0]          bcnt_q;
   logic [3:0]          nbits_q;
   logic                fill_q;
   logic [TW-1:0]       stop_len_q;

   logic [TW-1:0]       stop_len_cfg;
   logic [3:0]          word_len;
   logic [WORD_MAX-1:0] out_word;
   logic                take_brk, take_idle, take_data;

   always_comb begin
      unique case (cfg.stop)
         STOP_ONE:  stop_len_cfg = T_BIT;
         STOP_HALF: stop_len_cfg = T_HALF;
         STOP_TWO:  stop_len_cfg = T_TWO;
         default:   stop_len_cfg = T_ONEHALF;
      endcase
   end

   assign word_len = cfg.wide ? 4'd9 : 4'd8;

   // Word as it goes on the line: top bit dropped or replaced by parity
   always_comb begin
      out_word = tx_data;
      if (!cfg.wide) out_word[8] = 1'b0;
      if (cfg.par_en) begin
         if (cfg.wide) out_word[8] = word_parity(tx_data, 1'b1, cfg.par_odd);
         else          out_word[7] = word_parity(tx_data, 1'b0, cfg.par_odd);
      end
   end

   assign tx_ready  = (state_q == TX_IDLE);
   assign take_brk  = tx_ready && tx_break_req;
   assign take_idle = tx_ready && !tx_break_req && tx_idle_req;
   assign take_data = tx_ready && !tx_break_req && !tx_idle_req && tx_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= TX_IDLE;
         shreg_q    <= '1;
         tcnt_q     <= '0;
         bcnt_q     <= '0;
         nbits_q    <= '0;
         fill_q     <= 1'b1;
         stop_len_q <= T_BIT;
      end else begin
         unique case (state_q)
            TX_IDLE: begin
               tcnt_q <= '0;
               bcnt_q <= '0;
               if (take_brk) begin
                  shreg_q    <= '0;
                  fill_q     <= 1'b0;
                  nbits_q    <= word_len + 4'd2;
                  stop_len_q <= (stop_len_cfg < T_BIT) ? T_BIT : stop_len_cfg;
                  state_q    <= TX_BITS;
               end else if (take_idle) begin
                  shreg_q    <= '1;
                  fill_q     <= 1'b1;
                  nbits_q    <= word_len + 4'd1;
                  stop_len_q <= stop_len_cfg;
                  state_q    <= TX_BITS;
               end else if (take_data) begin
                  shreg_q    <= {out_word, 1'b0};
                  fill_q     <= 1'b1;
                  nbits_q    <= word_len + 4'd1;
                  stop_len_q <= stop_len_cfg;
                  state_q    <= TX_BITS;
               end
            end
            TX_BITS: begin
               if (tick) begin
                  if (tcnt_q == T_BIT - TW'(1)) begin
                     tcnt_q  <= '0;
                     shreg_q <= {fill_q, shreg_q[FW-1:1]};
                     if (bcnt_q == nbits_q - 4'd1) begin
                        state_q <= TX_STOP;
                     end else begin
                        bcnt_q <= bcnt_q + 4'd1;
                     end
                  end else begin
                     tcnt_q <= tcnt_q + TW'(1);
                  end
               end
            end
            TX_STOP: begin
               if (tick) begin
                  if (tcnt_q == stop_len_q - TW'(1)) begin
                     tcnt_q  <= '0;
                     state_q <= TX_IDLE;
                  end else begin
                     tcnt_q <= tcnt_q + TW'(1);
                  end
               end
            end
            default: state_q <= TX_IDLE;
         endcase
      end
   end

   assign txd = (state_q == TX_BITS) ? shreg_q[0] : 1'b1;

   AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && !tx_idle_req && (tx_valid || tx_break_req)) |=> !txd); // R3

   AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && !$past(tx_ready)) |-> $past(txd)); // R3

   AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && tx_idle_req && !tx_break_req) |=> txd); // R8

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
   import uart_fmt_pkg::*;
#(
   parameter int unsigned OVS    = 16,
   parameter int unsigned SYNC_N = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  frame_cfg_t          cfg,
   input  logic                rxd,
   output logic [WORD_MAX-1:0] rx_data,
   output logic                rx_valid,
   output logic                rx_par_err,
   output logic                rx_frm_err,
   output logic                rx_brk
);

   localparam int unsigned TW = $clog2(OVS + 1);
   localparam logic [TW-1:0] T_BIT       = TW'(OVS);
   localparam logic [TW-1:0] T_MID       = TW'(OVS/2);
   localparam logic [TW-1:0] T_HALF_SAMP = TW'(OVS/2 + OVS/4);

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

   logic line;
   logic line_prev_q;

   generate
      if (SYNC_N == 1) begin : g_sync_one
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b1;
            else        s_q <= rxd;
         end
         assign line = s_q;
      end else begin : g_sync_chain
         logic [SYNC_N-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '1;
            else        s_q <= {s_q[SYNC_N-2:0], rxd};
         end
         assign line = s_q[SYNC_N-1];
      end
   endgenerate

   rx_state_e           state_q;
   frame_cfg_t          cfg_q;
   logic [TW-1:0]       tcnt_q;
   logic [3:0]          bidx_q;
   logic [WORD_MAX-1:0] word_q;
   logic [3:0]          last_idx;
   logic [TW-1:0]       stop_wait;

   assign last_idx  = cfg_q.wide ? 4'd8 : 4'd7;
   assign stop_wait = (cfg_q.stop == STOP_HALF) ? T_HALF_SAMP : T_BIT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= RX_IDLE;
         cfg_q       <= '0;
         tcnt_q      <= '0;
         bidx_q      <= '0;
         word_q      <= '0;
         line_prev_q <= 1'b1;
         rx_data     <= '0;
         rx_valid    <= 1'b0;
         rx_par_err  <= 1'b0;
         rx_frm_err  <= 1'b0;
         rx_brk      <= 1'b0;
      end else begin
         line_prev_q <= line;
         rx_valid    <= 1'b0;
         unique case (state_q)
            RX_IDLE: begin
               if (line_prev_q && !line) begin
                  state_q <= RX_START;
                  cfg_q   <= cfg;
                  tcnt_q  <= '0;
                  bidx_q  <= '0;
                  word_q  <= '0;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (tcnt_q == T_MID - TW'(1)) begin
                     tcnt_q  <= '0;
                     state_q <= line ? RX_IDLE : RX_DATA;
                  end else begin
                     tcnt_q <= tcnt_q + TW'(1);
                  end
               end
            end
            RX_DATA: begin
               if (tick) begin
                  if (tcnt_q == T_BIT - TW'(1)) begin
                     tcnt_q         <= '0;
                     word_q[bidx_q] <= line;
                     if (bidx_q == last_idx) state_q <= RX_STOP;
                     else                    bidx_q  <= bidx_q + 4'd1;
                  end else begin
                     tcnt_q <= tcnt_q + TW'(1);
                  end
               end
            end
            RX_STOP: begin
               if (tick) begin
                  if (tcnt_q == stop_wait - TW'(1)) begin
                     tcnt_q     <= '0;
                     state_q    <= RX_IDLE;
                     rx_valid   <= 1'b1;
                     rx_data    <= word_q;
                     rx_frm_err <= !line;
                     rx_brk     <= (word_q == '0) && !line;
                     rx_par_err <= cfg_q.par_en && ((^word_q) ^ cfg_q.par_odd);
                  end else begin
                     tcnt_q <= tcnt_q + TW'(1);
                  end
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid); // R10

   AST_RX_BRK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_brk) |-> (rx_frm_err && rx_data == '0)); // R13

endmodule

// File: rtl/uart_frame_xcvr.sv
module uart_frame_xcvr
   import uart_fmt_pkg::*;
#(
   parameter int unsigned DIV_W  = 16,
   parameter int unsigned OVS    = 16,
   parameter int unsigned SYNC_N = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DIV_W-1:0]    cfg_div,
   input  logic                cfg_wide,
   input  logic                cfg_par_en,
   input  logic                cfg_par_odd,
   input  logic [1:0]          cfg_stop,
   input  logic [WORD_MAX-1:0] tx_data,
   input  logic                tx_valid,
   output logic                tx_ready,
   input  logic                tx_idle_req,
   input  logic                tx_break_req,
   output logic                txd,
   input  logic                rxd,
   output logic [WORD_MAX-1:0] rx_data,
   output logic                rx_valid,
   output logic                rx_par_err,
   output logic                rx_frm_err,
   output logic                rx_brk
);

   if (OVS < 4 || (OVS % 4) != 0) begin : g_bad_ovs
      $error("OVS must be a multiple of 4 and at least 4");
   end
   if (DIV_W == 0) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end
   if (SYNC_N == 0) begin : g_bad_sync
      $error("SYNC_N must be at least 1");
   end

   frame_cfg_t cfg;
   logic       tick;

   assign cfg.wide    = cfg_wide;
   assign cfg.par_en  = cfg_par_en;
   assign cfg.par_odd = cfg_par_odd;
   assign cfg.stop    = stop_code_e'(cfg_stop);

   uart_baud_tick #(.DIV_W(DIV_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_div (cfg_div),
      .tick    (tick)
   );

   uart_tx_core #(.OVS(OVS)) u_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .cfg          (cfg),
      .tx_data      (tx_data),
      .tx_valid     (tx_valid),
      .tx_idle_req  (tx_idle_req),
      .tx_break_req (tx_break_req),
      .tx_ready     (tx_ready),
      .txd          (txd)
   );

   uart_rx_core #(.OVS(OVS), .SYNC_N(SYNC_N)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .cfg        (cfg),
      .rxd        (rxd),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .rx_par_err (rx_par_err),
      .rx_frm_err (rx_frm_err),
      .rx_brk     (rx_brk)
   );

endmodule

// File: tb/tb_uart_frame_xcvr.sv
module tb_uart_frame_xcvr;

   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 2;
   localparam int BITC       = 16 * DIV;
   localparam int TOL        = 3;

   logic        clk, rst_n;
   logic [15:0] cfg_div;
   logic        cfg_wide, cfg_par_en, cfg_par_odd;
   logic [1:0]  cfg_stop;
   logic [8:0]  tx_data;
   logic        tx_valid, tx_ready, tx_idle_req, tx_break_req, txd;
   logic        rxd, loop_en, rxd_drv;
   logic [8:0]  rx_data;
   logic        rx_valid, rx_par_err, rx_frm_err, rx_brk;

   int checks = 0;
   int errors = 0;
   int cap_cnt = 0;
   logic [8:0] cap_data;
   logic cap_par, cap_frm, cap_brk;

   assign rxd = loop_en ? txd : rxd_drv;

   uart_frame_xcvr dut (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_wide(cfg_wide),
      .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_idle_req(tx_idle_req), .tx_break_req(tx_break_req), .txd(txd),
      .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         cap_cnt  = cap_cnt + 1;
         cap_data = rx_data;
         cap_par  = rx_par_err;
         cap_frm  = rx_frm_err;
         cap_brk  = rx_brk;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit near(input int a, input int e);
      return (a >= e - TOL) && (a <= e + TOL);
   endfunction

   task automatic set_fmt(input logic w, input logic pe, input logic po, input logic [1:0] st);
      @(negedge clk);
      cfg_wide = w; cfg_par_en = pe; cfg_par_odd = po; cfg_stop = st;
   endtask

   // kind 0: data, 1: idle, 2: break, 3: all three at once
   task automatic start_tx(input int kind, input logic [8:0] w);
      @(negedge clk);
      tx_data = w;
      tx_valid     = (kind == 0 || kind == 3);
      tx_idle_req  = (kind == 1 || kind == 3);
      tx_break_req = (kind == 2 || kind == 3);
      @(negedge clk);
      tx_valid = 1'b0; tx_idle_req = 1'b0; tx_break_req = 1'b0;
   endtask

   task automatic wait_busy(output int n);
      n = 0;
      while (!tx_ready && n < 5000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic loop_word(input logic [8:0] w, output int busy);
      loop_en = 1'b1;
      cap_cnt = 0;
      start_tx(0, w);
      wait_busy(busy);
      repeat (40) @(negedge clk);
   endtask

   task automatic drive_bits(input logic [11:0] bits, input int n);
      loop_en = 1'b0;
      cap_cnt = 0;
      for (int i = 0; i < n; i++) begin
         rxd_drv = bits[i];
         repeat (BITC) @(negedge clk);
      end
      rxd_drv = 1'b1;
      repeat (BITC * 2) @(negedge clk);
   endtask

   task automatic t_reset;
      chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
      chk(tx_ready == 1'b1, "R1", "tx_ready after reset", tx_ready, 1);
      chk(rx_valid == 1'b0, "R1", "rx_valid after reset", rx_valid, 0);
   endtask

   task automatic t_shape_8n1;
      logic [9:0] exp_line;
      int busy;
      set_fmt(1'b0, 1'b0, 1'b0, 2'b00);
      exp_line = {1'b1, 8'hA5, 1'b0};
      loop_en = 1'b1;
      cap_cnt = 0;
      start_tx(0, 9'h0A5);
      repeat (BITC/2 - 1) @(negedge clk);
      for (int k = 0; k < 10; k++) begin
         chk(txd == exp_line[k], "R3", $sformatf("line bit %0d", k), txd, exp_line[k]);
         repeat (BITC) @(negedge clk);
      end
      wait_busy(busy);
      repeat (40) @(negedge clk);
      chk(cap_cnt == 1 && cap_data == 9'h0A5, "R10", "8N1 loopback word", cap_data, 9'h0A5);
      chk(!cap_par && !cap_frm && !cap_brk, "R10", "8N1 flags", {cap_par, cap_frm, cap_brk}, 0);
   endtask

   task automatic t_word_len;
      int busy;
      set_fmt(1'b0, 1'b0, 1'b0, 2'b00);
      loop_word(9'h1A5, busy);
      chk(cap_data == 9'h0A5, "R4", "8-bit drops bit 8", cap_data, 9'h0A5);
      set_fmt(1'b1, 1'b0, 1'b0, 2'b00);
      loop_word(9'h1C3, busy);
      chk(cap_data == 9'h1C3, "R4", "9-bit word", cap_data, 9'h1C3);
      chk(near(busy, 2 * (10 * 16 + 16)), "R4", "9-bit frame length", busy, 2 * 176);
   endtask

   task automatic t_parity;
      int busy;
      set_fmt(1'b0, 1'b1, 1'b0, 2'b00);
      loop_word(9'h083, busy);
      chk(cap_data == 9'h003 && !cap_par, "R5", "even parity replaces bit 7", cap_data, 9'h003);
      set_fmt(1'b1, 1'b1, 1'b1, 2'b00);
      loop_word(9'h0FF, busy);
      chk(cap_data == 9'h1FF && !cap_par, "R5", "odd parity in bit 8", cap_data, 9'h1FF);
   endtask

   task automatic t_stop_lengths;
      int exp_ticks [4] = '{16, 8, 32, 24};
      int busy;
      for (int c = 0; c < 4; c++) begin
         set_fmt(1'b0, 1'b0, 1'b0, 2'(c));
         loop_word(9'h05A, busy);
         chk(near(busy, 2 * (144 + exp_ticks[c])), "R6",
             $sformatf("busy with stop code %0d", c), busy, 2 * (144 + exp_ticks[c]));
         chk(cap_cnt == 1 && cap_data == 9'h05A && !cap_frm, "R10",
             $sformatf("receive with stop code %0d", c), cap_data, 9'h05A);
      end
   endtask

   task automatic t_divider;
      int busy;
      set_fmt(1'b0, 1'b0, 1'b0, 2'b00);
      cfg_div = 16'd1;
      loop_word(9'h033, busy);
      chk(near(busy, 160), "R2", "divider 1 frame length", busy, 160);
      cfg_div = 16'd0;
      loop_word(9'h033, busy);
      chk(near(busy, 160), "R2", "divider 0 frame length", busy, 160);
      cfg_div = 16'(DIV);
      repeat (10) @(negedge clk);
   endtask

   task automatic t_break;
      int low_n = 0;
      int total = 0;
      set_fmt(1'b0, 1'b0, 1'b0, 2'b00);
      loop_en = 1'b1;
      cap_cnt = 0;
      start_tx(3, 9'h0FF);
      while (txd == 1'b0 && low_n < 5000) begin
         low_n++;
         @(negedge clk);
      end
      total = low_n;
      while (!tx_ready && total < 5000) begin
         total++;
         @(negedge clk);
      end
      repeat (40) @(negedge clk);
      chk(near(low_n, 10 * BITC), "R7", "break low length", low_n, 10 * BITC);
      chk(near(total, 2 * 176), "R7", "break with high stop", total, 2 * 176);
      chk(cap_cnt == 1 && cap_brk && cap_frm && cap_data == 9'h000, "R13",
          "break flags", {cap_brk, cap_frm}, 3);
   endtask

   task automatic t_idle;
      int n = 0;
      int lows = 0;
      set_fmt(1'b0, 1'b0, 1'b0, 2'b00);
      loop_en = 1'b1;
      cap_cnt = 0;
      start_tx(1, 9'h000);
      while (!tx_ready && n < 5000) begin
         if (!txd) lows++;
         n++;
         @(negedge clk);
      end
      repeat (40) @(negedge clk);
      chk(lows == 0, "R8", "idle frame low cycles", lows, 0);
      chk(near(n, 320), "R8", "idle frame length", n, 320);
      chk(cap_cnt == 0, "R8", "no frame received for idle", cap_cnt, 0);
   endtask

   task automatic t_rx_parity;
      set_fmt(1'b0, 1'b1, 1'b0, 2'b00);
      drive_bits({2'b11, 1'b1, 8'h01, 1'b0}, 10);
      chk(cap_cnt == 1 && cap_par, "R11", "parity error flagged", cap_par, 1);
      chk(cap_data == 9'h001 && !cap_frm, "R11", "word with parity error", cap_data, 9'h001);
      drive_bits({2'b11, 1'b1, 8'h81, 1'b0}, 10);
      chk(cap_cnt == 1 && !cap_par, "R11", "matching parity clean", cap_par, 0);
   endtask

   task automatic t_rx_framing;
      set_fmt(1'b0, 1'b0, 1'b0, 2'b00);
      drive_bits({2'b11, 1'b0, 8'h55, 1'b0}, 10);
      chk(cap_cnt == 1 && cap_frm && !cap_brk, "R12", "framing error flags",
          {cap_frm, cap_brk}, 2);
      chk(cap_data == 9'h055, "R12", "word with framing error", cap_data, 9'h055);
   endtask

   task automatic t_false_start;
      set_fmt(1'b0, 1'b0, 1'b0, 2'b00);
      loop_en = 1'b0;
      cap_cnt = 0;
      @(negedge clk);
      rxd_drv = 1'b0;
      repeat (6) @(negedge clk);
      rxd_drv = 1'b1;
      repeat (400) @(negedge clk);
      chk(cap_cnt == 0, "R9", "glitch ignored", cap_cnt, 0);
      drive_bits({2'b11, 1'b1, 8'h3C, 1'b0}, 10);
      chk(cap_cnt == 1 && cap_data == 9'h03C, "R9", "frame after glitch", cap_data, 9'h03C);
   endtask

   initial begin
      rst_n = 1'b0; cfg_div = 16'(DIV);
      cfg_wide = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_stop = 2'b00;
      tx_data = '0; tx_valid = 1'b0; tx_idle_req = 1'b0; tx_break_req = 1'b0;
      loop_en = 1'b1; rxd_drv = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_shape_8n1();
      t_word_len();
      t_parity();
      t_stop_lengths();
      t_divider();
      t_break();
      t_idle();
      t_rx_parity();
      t_rx_framing();
      t_false_start();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule